// File: doc/BRIEF.md
# Rate Converter Parameter RAM Port

This block is one 32-bit host control word. Through it, software reaches a 128-entry, 16-bit parameter memory that belongs to a sample rate converter. The same word also carries the live disable controls for the converter and for its three channel accumulators. To store a value, the host writes the word with the store-enable bit set. The address and data come from the word. If the store-enable bit is clear, the write fetches the addressed entry instead, and the value appears in the low half of the word when the access completes.

Every accepted access raises a read-only busy flag for a fixed number of cycles. A write that arrives while busy is discarded and sets a sticky error output. The disable bits sit in the same word as the access fields, so software copies them into every access it issues. A 3-bit phase field reports where the converter is in its processing cycle. The phase counter runs only while the converter is enabled, and phase 1 marks the safe moment to issue codec commands. The converter datapath itself is not part of this block. It is represented only by the phase counter and the disable outputs.

Field layout of the word: bits 31:25 address, bit 24 store enable, bit 23 busy, bit 22 converter off, bits 21/20/19 accumulator off for playback 1, playback 2 and record, bits 18:16 phase, bits 15:0 data.

Top module: `src_param_port`

## Requirements
- R1: After reset the word reads 0x0078_0000, `src_off` is 1, `acc_off` is 3'b111 and `drop_err` is 0.
- R2: An accepted write with bit 24 set stores bits 15:0 at the entry selected by bits 31:25. A later fetch of that entry returns the stored value.
- R3: An accepted write with bit 24 clear is a fetch. Bits 15:0 keep their previous value while busy is high and take the entry's contents on the same edge that clears busy. A store leaves bits 15:0 unchanged.
- R4: Bit 23 rises on the edge that accepts a write and stays high for exactly BUSY_CYC cycles.
- R5: A write presented while bit 23 is high is dropped. It changes no memory entry, no disable bit and no field. It sets `drop_err`, which then stays set until reset.
- R6: An accepted write loads bits 22:19 into the disable controls. `src_off` follows bit 22. `acc_off[2]`, `acc_off[1]` and `acc_off[0]` follow bits 21, 20 and 19 respectively. The word reads these bits back as written.
- R7: While bit 22 is clear, bits 18:16 start at 0 and step by one each cycle, wrapping from PHASE_CYC-1 to 0. Once bit 22 is set, the phase is 0 from the second edge onward and holds there.
- R8: Bits 31:24 read back the address and store-enable value of the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 32 | Word written by the host |
| host_rdata | output | 32 | Current view of the control word |
| src_off | output | 1 | Converter disable |
| acc_off | output | 3 | Accumulator update disables: [2] playback 1, [1] playback 2, [0] record |
| drop_err | output | 1 | Sticky flag: a write arrived while busy |

## Verification
A busy counter that is stuck or mis-sized shows up at bit 23 within BUSY_CYC+1 cycles of the first access. Either the count of busy cycles is wrong, or a write that should be accepted is dropped and raises `drop_err` at once. A fetch result latched on the wrong edge shows in bits 15:0 during the busy window or at its end. A memory write going to the wrong entry stays hidden until that entry is fetched again, so the tests read back both boundary addresses. A fault in the phase counter shows within one phase period as a value out of sequence, or as a nonzero value one cycle after the converter is disabled.

// File: rtl/src_port_pkg.sv
package src_port_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned PH_W     = 3;
  localparam int unsigned NUM_ACC  = 3;

  // field positions that software decodes
  localparam int unsigned ADDR_LSB = 25;
  localparam int unsigned WE_BIT   = 24;
  localparam int unsigned BUSY_BIT = 23;
  localparam int unsigned OFF_BIT  = 22;
  localparam int unsigned ACC_LSB  = 19;
  localparam int unsigned PH_LSB   = 16;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic               we;
    logic               busy;
    logic               conv_off;
    logic [NUM_ACC-1:0] acc_off;
    logic [PH_W-1:0]    phase;
    logic [DATA_W-1:0]  data;
  } ctl_word_t;
endpackage

// File: rtl/src_ctrl_regs.sv
module src_ctrl_regs
  import src_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               drop,
  input  ctl_word_t          wr_word,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               we_q,
  output logic               conv_off_q,
  output logic [NUM_ACC-1:0] acc_off_q,
  output logic               err_q
);
  logic [ADDR_W-1:0]  addr_d;
  logic               we_d;
  logic               conv_off_d;
  logic [NUM_ACC-1:0] acc_off_d;
  logic               err_d;

  always_comb begin
    addr_d     = addr_q;
    we_d       = we_q;
    conv_off_d = conv_off_q;
    acc_off_d  = acc_off_q;
    err_d      = err_q | drop;
    if (accept) begin
      addr_d     = wr_word.addr;
      we_d       = wr_word.we;
      conv_off_d = wr_word.conv_off;
      acc_off_d  = wr_word.acc_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      we_q       <= 1'b0;
      conv_off_q <= 1'b1;
      acc_off_q  <= '1;
      err_q      <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      we_q       <= we_d;
      conv_off_q <= conv_off_d;
      acc_off_q  <= acc_off_d;
      err_q      <= err_d;
    end
  end
endmodule

// File: rtl/src_param_ram.sv
module src_param_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/src_access_seq.sv
module src_access_seq #(
  parameter int unsigned BUSY_CYC = 4,
  parameter int unsigned DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          fetch,
  input  logic [DW-1:0] ram_q,
  output logic          busy,
  output logic [DW-1:0] rd_q
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [DW-1:0]    rd_d;
  logic             last_cyc;

  assign busy     = (cnt_q != '0);
  assign last_cyc = (cnt_q == CNT_ONE);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    rd_d   = rd_q;
    if (accept) begin
      cnt_d  = CNT_LOAD;
      pend_d = fetch;
    end else if (busy) begin
      cnt_d = cnt_q - CNT_ONE;
      if (last_cyc) begin
        pend_d = 1'b0;
        if (pend_q) begin
          rd_d = ram_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/src_phase_gen.sv
module src_phase_gen #(
  parameter int unsigned PHASE_CYC = 6,
  parameter int unsigned PW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_off,
  output logic [PW-1:0] phase_q
);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASE_CYC - 1);

  logic [PW-1:0] phase_d;

  always_comb begin
    if (conv_off) begin
      phase_d = '0;
    end else if (phase_q == PH_LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/src_param_port.sv
module src_param_port
  import src_port_pkg::*;
#(
  parameter int unsigned BUSY_CYC  = 4,
  parameter int unsigned PHASE_CYC = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        src_off,
  output logic [2:0]  acc_off,
  output logic        drop_err
);
  ctl_word_t          wr_word;
  ctl_word_t          view;
  logic               busy;
  logic               accept;
  logic               drop;
  logic [ADDR_W-1:0]  addr_q;
  logic               we_q;
  logic               conv_off_q;
  logic [NUM_ACC-1:0] acc_off_q;
  logic [DATA_W-1:0]  ram_q;
  logic [DATA_W-1:0]  rd_q;
  logic [PH_W-1:0]    phase_q;
  logic               unused_bits;

  assign wr_word     = ctl_word_t'(host_wdata);
  assign unused_bits = ^{wr_word.busy, wr_word.phase};
  assign accept      = host_wr & ~busy;
  assign drop        = host_wr & busy;

  src_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .drop       (drop),
    .wr_word    (wr_word),
    .addr_q     (addr_q),
    .we_q       (we_q),
    .conv_off_q (conv_off_q),
    .acc_off_q  (acc_off_q),
    .err_q      (drop_err)
  );

  src_param_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk     (clk),
    .wr_en   (accept & wr_word.we),
    .wr_addr (wr_word.addr),
    .wr_data (wr_word.data),
    .rd_addr (addr_q),
    .rd_data (ram_q)
  );

  src_access_seq #(.BUSY_CYC(BUSY_CYC), .DW(DATA_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .fetch  (~wr_word.we),
    .ram_q  (ram_q),
    .busy   (busy),
    .rd_q   (rd_q)
  );

  src_phase_gen #(.PHASE_CYC(PHASE_CYC), .PW(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_off (conv_off_q),
    .phase_q  (phase_q)
  );

  always_comb begin
    view.addr     = addr_q;
    view.we       = we_q;
    view.busy     = busy;
    view.conv_off = conv_off_q;
    view.acc_off  = acc_off_q;
    view.phase    = phase_q;
    view.data     = rd_q;
  end

  assign host_rdata = view;
  assign src_off    = conv_off_q;
  assign acc_off    = acc_off_q;
endmodule

// File: rtl/src_param_port_chk.sv
module src_param_port_chk #(
  parameter int unsigned PHASE_CYC = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [31:0] host_rdata,
  input logic        src_off,
  input logic [2:0]  acc_off,
  input logic        drop_err
);
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rdata[23]) |=> host_rdata[23]); // R4
  AST_DROP_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rdata[23]) |=> ($stable(src_off) && $stable(acc_off) && drop_err)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err); // R5
  AST_DATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_rdata[15:0]) |-> $fell(host_rdata[23])); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[18:16] < 3'(PHASE_CYC)); // R7
  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    src_off |=> (!src_off || host_rdata[18:16] == 3'd0)); // R7
  AST_OFF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (src_off == host_rdata[22]) && (acc_off == host_rdata[21:19])); // R6
endmodule

bind src_param_port src_param_port_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .src_off    (src_off),
  .acc_off    (acc_off),
  .drop_err   (drop_err)
);

// File: tb/src_param_port_bench.sv
module src_param_port_bench;
  localparam int BUSY_CYC  = 4;
  localparam int PHASE_CYC = 6;

  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        src_off;
  logic [2:0]  acc_off;
  logic        drop_err;

  int total = 0;
  int bad   = 0;

  src_param_port #(.BUSY_CYC(BUSY_CYC), .PHASE_CYC(PHASE_CYC)) u_src_param_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .src_off    (src_off),
    .acc_off    (acc_off),
    .drop_err   (drop_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic [6:0] a, input logic we,
                                     input logic [3:0] off, input logic [15:0] d);
    return {a, we, 1'b0, off, 3'b000, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    host_wr    = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic wait_idle();
    while (host_rdata[23]) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 word", host_rdata, 32'h0078_0000);
    check("R1 src_off", {31'd0, src_off}, 32'd1);
    check("R1 acc_off", {29'd0, acc_off}, 32'd7);
    check("R1 drop_err", {31'd0, drop_err}, 32'd0);
  endtask

  task automatic t_store_fetch();
    wr(mk(7'd5, 1'b1, 4'hF, 16'hBEEF));
    for (int i = 0; i < BUSY_CYC; i++) begin
      check("R4 busy high", {31'd0, host_rdata[23]}, 32'd1);
      check("R3 data held on store", {16'd0, host_rdata[15:0]}, 32'd0);
      @(negedge clk);
    end
    check("R4 busy low", {31'd0, host_rdata[23]}, 32'd0);
    check("R8 addr/we", {24'd0, host_rdata[31:24]}, {24'd0, 7'd5, 1'b1});
    wr(mk(7'd5, 1'b0, 4'hF, 16'h0000));
    for (int i = 0; i < BUSY_CYC; i++) begin
      check("R3 data held while busy", {16'd0, host_rdata[15:0]}, 32'd0);
      @(negedge clk);
    end
    check("R2 fetch value", {16'd0, host_rdata[15:0]}, 32'h0000_BEEF);
    check("R8 addr/we fetch", {24'd0, host_rdata[31:24]}, {24'd0, 7'd5, 1'b0});
  endtask

  task automatic t_bounds();
    wr(mk(7'd0, 1'b1, 4'hF, 16'h1234)); wait_idle();
    wr(mk(7'd127, 1'b1, 4'hF, 16'hA5C3)); wait_idle();
    wr(mk(7'd0, 1'b0, 4'hF, 16'hFFFF)); wait_idle();
    check("R2 entry 0", {16'd0, host_rdata[15:0]}, 32'h0000_1234);
    wr(mk(7'd127, 1'b0, 4'hF, 16'h0)); wait_idle();
    check("R2 entry 127", {16'd0, host_rdata[15:0]}, 32'h0000_A5C3);
  endtask

  task automatic t_drop();
    check("R5 err clear before", {31'd0, drop_err}, 32'd0);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = mk(7'd9, 1'b1, 4'hF, 16'h1111);
    @(negedge clk);
    host_wdata = mk(7'd9, 1'b1, 4'h0, 16'h2222);
    @(negedge clk);
    host_wr = 1'b0;
    check("R5 err set", {31'd0, drop_err}, 32'd1);
    check("R5 src_off kept", {31'd0, src_off}, 32'd1);
    check("R5 acc_off kept", {29'd0, acc_off}, 32'd7);
    wait_idle();
    wr(mk(7'd9, 1'b0, 4'hF, 16'h0)); wait_idle();
    check("R5 entry not overwritten", {16'd0, host_rdata[15:0]}, 32'h0000_1111);
    check("R5 err sticky", {31'd0, drop_err}, 32'd1);
  endtask

  task automatic t_disables();
    wr(mk(7'd1, 1'b1, 4'b1010, 16'h0)); wait_idle();
    check("R6 src_off", {31'd0, src_off}, 32'd1);
    check("R6 acc_off", {29'd0, acc_off}, 32'b010);
    check("R6 readback", {28'd0, host_rdata[22:19]}, 32'b1010);
    wr(mk(7'd1, 1'b1, 4'b1101, 16'h0)); wait_idle();
    check("R6 acc_off p1/rec", {29'd0, acc_off}, 32'b101);
  endtask

  task automatic t_phase();
    wr(mk(7'd2, 1'b1, 4'b0000, 16'h0));
    for (int k = 0; k < 2 * PHASE_CYC + 1; k++) begin
      check("R7 phase step", {29'd0, host_rdata[18:16]}, k % PHASE_CYC);
      @(negedge clk);
    end
    wait_idle();
    wr(mk(7'd2, 1'b1, 4'b1000, 16'h0));
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R7 phase held", {29'd0, host_rdata[18:16]}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_fetch();
    t_bounds();
    t_drop();
    t_disables();
    t_phase();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule